// File: doc/BRIEF.md
# Runtime-Loadable Eight-Tap FIR Filter

This block is an eight-tap direct-form FIR filter for signed 16-bit samples. Its coefficients are signed Q1.15 values. Each accepted input sample moves the delay line forward by one place. The block then forms the weighted sum of the new sample and the seven samples before it. That sum is scaled back to Q1.15, clipped to the 16-bit range and placed in an output register. The output register carries a one-cycle valid flag.

A controller can change the filter response while it runs. The write port takes a tap index, a 16-bit value and a strobe, and each strobe replaces one coefficient. After reset the coefficients give an identity response, so the block passes samples through with only the Q1.15 rounding of 0x7FFF. A synchronous clear input empties the sample history and the output register and leaves the loaded coefficients in place.

The input stream is valid-only and has no back-pressure. The block accepts a sample on every cycle in which `s_valid` is high, including back-to-back cycles. The output is a strobe with no ready input, so a consumer must take `m_data` in the cycle `m_valid` is high. A bypass path around the block, if one is needed, sits outside it.

Top module: `rtfir_core`

## Requirements
- R1: After reset, `m_valid` and `m_data` are 0 and the sample history is zero. Tap 0 holds 0x7FFF and taps 1 to 7 hold 0.
- R2: When `s_valid` is high in a cycle and `soft_clr` is low, the sample is taken at that clock edge. In the next cycle `m_data` equals sat((sum over k=0..7 of c[k]*x[n-k]) >>> 15). Here x[n] is the sample just taken, x[n-k] is the sample accepted k samples earlier (0 if no such sample exists since reset or clear), c[k] is tap k, and the shift is arithmetic (floor).
- R3: `m_valid` is high for exactly one cycle after each accepted sample and is low in every other cycle.
- R4: In a cycle with `s_valid` and `soft_clr` both low, the sample history and `m_data` keep their values.
- R5: When `cw_en` is high, `cw_val` is loaded into tap `cw_idx` (0 to 7) at that clock edge. Tap k weights the sample k places back in the history.
- R6: A coefficient write takes effect from the next accepted sample. A sample that arrives in the same cycle as a write is filtered with the old value of that tap.
- R7: The shifted sum is saturated to the range -32768 to 32767. The 35-bit accumulator never wraps, even with all taps at -32768 and all samples at -32768.
- R8: `soft_clr` clears the history, `m_data` and `m_valid` at the next edge and leaves all coefficients unchanged. A sample offered in the same cycle is dropped. A coefficient write in the same cycle still takes place.
- R9: With all eight taps set to 0x1000, the output is the mean of the last eight samples (floor). For a constant input of 8000 held for eight samples, the output is 8000.
- R10: Back-to-back samples on consecutive cycles are all accepted, and each one produces its own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of history and output |
| s_valid | input | 1 | Input sample strobe |
| s_data | input | 16 | Signed input sample |
| cw_en | input | 1 | Coefficient write strobe |
| cw_idx | input | 3 | Tap index for the write |
| cw_val | input | 16 | Signed Q1.15 coefficient value |
| m_valid | output | 1 | One-cycle output strobe |
| m_data | output | 16 | Signed filtered output |

## Verification
The hardest case to reach from the ports is a coefficient write that lands in the same cycle as a sample. The old and new coefficient values differ only in that one cycle's result, so a check made one sample later would miss the error. Directed steps place a write and a sample together and then check that result at once. The random phase also raises `cw_en` together with `s_valid`.

The saturation limits of the 35-bit accumulator are reached only with every tap and every history slot at full scale. Directed sequences load every tap with -32768 or 0x7FFF and feed eight full-scale samples to reach them.

// File: rtl/rtfir_pkg.sv
package rtfir_pkg;
  localparam int unsigned RTFIR_TAPS  = 8;
  localparam int unsigned RTFIR_DW    = 16;
  localparam int unsigned RTFIR_CW    = 16;
endpackage

// File: rtl/rtfir_coef_bank.sv
module rtfir_coef_bank #(
  parameter int unsigned NTAP = rtfir_pkg::RTFIR_TAPS,
  parameter int unsigned CW   = rtfir_pkg::RTFIR_CW,
  localparam int unsigned IW  = $clog2(NTAP)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [CW-1:0]            wr_val,
  output logic [NTAP-1:0][CW-1:0]  coef_o
);
  localparam logic [CW-1:0] UNITY = {1'b0, {(CW-1){1'b1}}};

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        coef_o[k] <= (k == 0) ? UNITY : '0;
      else if (wr_en && (wr_idx == IW'(k)))
        coef_o[k] <= wr_val;
    end
  end

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> coef_o[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/rtfir_delay.sv
module rtfir_delay #(
  parameter int unsigned NTAP = rtfir_pkg::RTFIR_TAPS,
  parameter int unsigned DW   = rtfir_pkg::RTFIR_DW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift,
  input  logic                      clr,
  input  logic [DW-1:0]             din,
  output logic [NTAP-2:0][DW-1:0]   hist_o
);
  for (genvar k = 0; k < NTAP - 1; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hist_o[k] <= '0;
      else if (clr)
        hist_o[k] <= '0;
      else if (shift)
        hist_o[k] <= (k == 0) ? din : hist_o[(k == 0) ? 0 : k - 1];
    end
  end

  assert_hist_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !clr) |=> $stable(hist_o));
  assert_hist_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hist_o == '0));
endmodule

// File: rtl/rtfir_mac.sv
module rtfir_mac #(
  parameter int unsigned NTAP = rtfir_pkg::RTFIR_TAPS,
  parameter int unsigned DW   = rtfir_pkg::RTFIR_DW,
  parameter int unsigned CW   = rtfir_pkg::RTFIR_CW,
  localparam int unsigned AW   = DW + CW + $clog2(NTAP),
  localparam int unsigned FRAC = CW - 1
) (
  input  logic [DW-1:0]             din,
  input  logic [NTAP-2:0][DW-1:0]   hist,
  input  logic [NTAP-1:0][CW-1:0]   coef,
  output logic [DW-1:0]             y
);
  localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic [NTAP-1:0][DW-1:0] xv;
  logic signed [AW-1:0] prod [NTAP];
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] sh;

  assign xv = {hist, din};

  for (genvar k = 0; k < NTAP; k++) begin : g_mul
    logic signed [AW-1:0] xe, ce;
    assign xe = {{(AW-DW){xv[k][DW-1]}}, xv[k]};
    assign ce = {{(AW-CW){coef[k][CW-1]}}, coef[k]};
    assign prod[k] = xe * ce;
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAP; k++) acc = acc + prod[k];
    sh = acc >>> FRAC;
    if (sh > MAXV)      y = MAXV[DW-1:0];
    else if (sh < MINV) y = MINV[DW-1:0];
    else                y = sh[DW-1:0];
  end
endmodule

// File: rtl/rtfir_core.sv
module rtfir_core #(
  parameter int unsigned NTAP = rtfir_pkg::RTFIR_TAPS,
  parameter int unsigned DW   = rtfir_pkg::RTFIR_DW,
  parameter int unsigned CW   = rtfir_pkg::RTFIR_CW,
  localparam int unsigned IW  = $clog2(NTAP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic          cw_en,
  input  logic [IW-1:0] cw_idx,
  input  logic [CW-1:0] cw_val,
  output logic          m_valid,
  output logic [DW-1:0] m_data
);
  logic [NTAP-1:0][CW-1:0]  coef;
  logic [NTAP-2:0][DW-1:0]  hist;
  logic [DW-1:0]            y;
  logic                     take;

  assign take = s_valid && !soft_clr;

  rtfir_coef_bank #(.NTAP(NTAP), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cw_en), .wr_idx(cw_idx),
    .wr_val(cw_val), .coef_o(coef));

  rtfir_delay #(.NTAP(NTAP), .DW(DW)) u_dly (
    .clk(clk), .rst_n(rst_n), .shift(take), .clr(soft_clr),
    .din(s_data), .hist_o(hist));

  rtfir_mac #(.NTAP(NTAP), .DW(DW), .CW(CW)) u_mac (
    .din(s_data), .hist(hist), .coef(coef), .y(y));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (soft_clr) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      m_valid <= s_valid;
      if (s_valid) m_data <= y;
    end
  end

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> $past(s_valid && !soft_clr));
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && !soft_clr) |=> $stable(m_data));
  assert_coef_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_clr && !cw_en) |=> $stable(coef));
  assert_clear_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!m_valid && m_data == '0));
endmodule

// File: tb/sim_rtfir_core.sv
module sim_rtfir_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_clr = 1'b0;
  logic s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic cw_en = 1'b0;
  logic [2:0] cw_idx = '0;
  logic [15:0] cw_val = '0;
  logic m_valid;
  logic [15:0] m_data;

  int total = 0;
  int bad = 0;
  int hx [8];
  int cf [8];
  logic exp_v;
  logic [15:0] exp_d;

  always #5 clk = ~clk;

  rtfir_core u0 (.clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .s_valid(s_valid), .s_data(s_data), .cw_en(cw_en), .cw_idx(cw_idx),
    .cw_val(cw_val), .m_valid(m_valid), .m_data(m_data));

  function automatic logic [15:0] sat16(longint v);
    if (v > 32767) return 16'h7FFF;
    if (v < -32768) return 16'h8000;
    return v[15:0];
  endfunction

  function automatic logic [15:0] model_out();
    longint s = 0;
    for (int k = 0; k < 8; k++) s += longint'(hx[k]) * longint'(cf[k]);
    return sat16(s >>> 15);
  endfunction

  task automatic check(string req, logic [16:0] act, logic [16:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(string req, logic sv, logic [15:0] sd, logic we,
                      logic [2:0] wi, logic [15:0] wv, logic clr);
    s_valid = sv; s_data = sd; cw_en = we; cw_idx = wi; cw_val = wv;
    soft_clr = clr;
    @(posedge clk);
    if (clr) begin
      for (int k = 0; k < 8; k++) hx[k] = 0;
      exp_v = 1'b0; exp_d = '0;
    end else if (sv) begin
      for (int k = 7; k > 0; k--) hx[k] = hx[k-1];
      hx[0] = int'($signed(sd));
      exp_v = 1'b1; exp_d = model_out();
    end else exp_v = 1'b0;
    if (we) cf[wi] = int'($signed(wv));
    @(negedge clk);
    check(req, {m_valid, m_data}, {exp_v, exp_d});
  endtask

  task automatic load_all(logic [15:0] v);
    for (int k = 0; k < 8; k++) step("R5", 1'b0, 16'h0, 1'b1, 3'(k), v, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd4711);
    for (int k = 0; k < 8; k++) begin hx[k] = 0; cf[k] = 0; end
    cf[0] = 32767;
    exp_v = 1'b0; exp_d = '0;
    repeat (3) @(negedge clk);
    check("R1", {m_valid, m_data}, 17'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {m_valid, m_data}, 17'h0);
    // R1/R2: identity response after reset, with extremes
    step("R2", 1'b1, 16'd1000, 1'b0, 3'd0, 16'h0, 1'b0);
    check("R1", {1'b0, m_data}, {1'b0, 16'd999});
    step("R2", 1'b1, 16'h7FFF, 1'b0, 3'd0, 16'h0, 1'b0);
    step("R2", 1'b1, 16'h8000, 1'b0, 3'd0, 16'h0, 1'b0);
    step("R2", 1'b1, 16'hFFFF, 1'b0, 3'd0, 16'h0, 1'b0);
    // R3/R4: idle cycles keep output and drop valid
    step("R3", 1'b0, 16'h1234, 1'b0, 3'd0, 16'h0, 1'b0);
    step("R4", 1'b0, 16'h5555, 1'b0, 3'd0, 16'h0, 1'b0);
    // R9: moving average, R10 back to back
    load_all(16'h1000);
    for (int i = 0; i < 8; i++) step("R10", 1'b1, 16'd8000, 1'b0, 3'd0, 16'h0, 1'b0);
    check("R9", {m_valid, m_data}, {1'b1, 16'd8000});
    // R6: write together with a sample uses the old tap
    step("R6", 1'b1, 16'd800, 1'b1, 3'd0, 16'h7FFF, 1'b0);
    check("R6", {1'b0, m_data}, {1'b0, 16'd7100});
    step("R6", 1'b1, 16'd800, 1'b0, 3'd0, 16'h0, 1'b0);
    // R7: saturation at both ends
    load_all(16'h8000);
    for (int i = 0; i < 8; i++) step("R7", 1'b1, 16'h8000, 1'b0, 3'd0, 16'h0, 1'b0);
    check("R7", {m_valid, m_data}, {1'b1, 16'h7FFF});
    load_all(16'h7FFF);
    for (int i = 0; i < 8; i++) step("R7", 1'b1, 16'h8000, 1'b0, 3'd0, 16'h0, 1'b0);
    check("R7", {m_valid, m_data}, {1'b1, 16'h8000});
    // R8: clear drops sample, keeps coefficients, allows write
    step("R8", 1'b1, 16'd300, 1'b1, 3'd1, 16'h4000, 1'b1);
    check("R8", {m_valid, m_data}, 17'h0);
    step("R8", 1'b1, 16'd1000, 1'b0, 3'd0, 16'h0, 1'b0);
    check("R8", {1'b0, m_data}, {1'b0, 16'd999});
    step("R8", 1'b1, 16'd1000, 1'b0, 3'd0, 16'h0, 1'b0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic sv, we, clr;
      sv  = ($urandom % 4) != 0;
      we  = ($urandom % 5) == 0;
      clr = ($urandom % 40) == 0;
      step("R2", sv, 16'($urandom), we, 3'($urandom), 16'($urandom), clr);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule